// File: doc/BRIEF.md
# Retire Buffer with Ordered Commit

This block keeps the program order of in-flight instructions in a speculative out-of-order core. When an instruction issues, the front end claims the slot at the tail of a circular buffer. The index of that slot comes back to the front end and serves as the tag under which the instruction's result will later arrive. Results come back in any order over a write-back port. Each one marks its slot complete and stores the payload: a value, plus an auxiliary address that is a store address for stores and the correct successor address for branches.

Retirement happens strictly from the head, one slot per cycle, and only once the head slot is complete. The kind recorded at issue decides the action. A register slot drives the register-file write port. A store slot drives the memory write port. A correctly predicted branch leaves silently. A mispredicted branch empties the whole buffer and emits a one-cycle redirect carrying the correct address. All retire outputs are decoded from registered state, so the front end sees them in the cycle after the completing write-back.

Top module: `retire_buffer`

## Requirements
- R1: After reset the buffer is empty: `allocReady` is 1, `allocTag` is 0, and `regWrEn`, `memWrEn` and `flushOut` are 0.
- R2: An accepted allocation claims the slot shown on `allocTag`. Successive accepted allocations receive consecutive tags that wrap from DEPTH-1 back to 0.
- R3: While DEPTH slots are live, `allocReady` is 0 and `allocReq` has no effect: `allocTag` holds and no extra slot is created.
- R4: Slots retire in allocation order and only once complete. A later slot that completes early waits until every older slot has retired.
- R5: A complete head slot of kind 0 or 3 retires with `regWrEn`=1, `regWrIdx` set to its destination and `regWrData` set to its value.
- R6: A complete head slot of kind 1 (store) retires with `memWrEn`=1, `memWrAddr` set to its auxiliary address, `memWrData` set to its value, and `regWrEn`=0.
- R7: A complete head slot of kind 2 (branch) with no misprediction retires with no register write, no memory write and no flush. The next slot may retire in the following cycle.
- R8: A complete head slot of kind 2 with its misprediction flag set raises `flushOut` for exactly one cycle, with `redirectPc` equal to its auxiliary address. Every slot is discarded, and in the next cycle the buffer is empty with `allocTag` equal to 0.
- R9: An allocation requested in the cycle in which `flushOut` is 1 is dropped.
- R10: A write-back whose tag names a slot that is not live (never allocated, or discarded by a flush) is ignored. It does not complete any slot that is later allocated at that index.
- R11: At most one slot retires per cycle, so at most one of `regWrEn`, `memWrEn` and `flushOut` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request to claim the tail slot |
| allocKind | input | 2 | Slot kind: 0 register, 1 store, 2 branch, 3 register |
| allocDest | input | REG_W | Destination register index |
| allocReady | output | 1 | A free slot exists |
| allocTag | output | TAG_W | Index of the slot the next accepted allocation claims |
| wbValid | input | 1 | Write-back strobe |
| wbTag | input | TAG_W | Slot being completed |
| wbValue | input | DATA_W | Result value or store data |
| wbAux | input | ADDR_W | Store address or correct branch target |
| wbMispredict | input | 1 | Branch was mispredicted |
| regWrEn | output | 1 | Register write at retirement |
| regWrIdx | output | REG_W | Register index written |
| regWrData | output | DATA_W | Register value written |
| memWrEn | output | 1 | Store write at retirement |
| memWrAddr | output | ADDR_W | Store address |
| memWrData | output | DATA_W | Store data |
| flushOut | output | 1 | One-cycle flush pulse |
| redirectPc | output | ADDR_W | Correct fetch address during the flush pulse |

## Verification
The bench builds the block with its defaults: DEPTH of 8, 32-bit value and address, and 5-bit register index. A depth of eight lets a short run fill the buffer completely, push the tail across the wrap point, and land a mispredicted branch on a slot near the end of the index range. The 32-bit payloads let each slot carry a distinct value and address, so any out-of-order or duplicated retirement shows up in the captured data.

// File: rtl/retire_pkg.sv
package retire_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_REGALT = 2'd3
  } slot_kind_e;

  // strobes from the control to the slot storage
  typedef struct packed {
    logic allocDo;
    logic commitDo;
    logic flushDo;
  } slot_strobe_t;

endpackage

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocReq,
  input  logic                      headDone,
  input  logic                      headMisBranch,
  output retire_pkg::slot_strobe_t strobe,
  output logic [TAG_W-1:0]          headPtr,
  output logic [TAG_W-1:0]          tailPtr,
  output logic [CNT_W-1:0]          occupancy,
  output logic                      allocReady
);

  logic [TAG_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] occQ;
  logic             liveAny;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    liveAny         = (occQ != '0);
    allocReady      = (occQ != CNT_W'(DEPTH));
    strobe.commitDo = liveAny && headDone;
    strobe.flushDo  = strobe.commitDo && headMisBranch;
    strobe.allocDo  = allocReq && allocReady && !strobe.flushDo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      occQ  <= '0;
    end else if (strobe.flushDo) begin
      headQ <= '0;
      tailQ <= '0;
      occQ  <= '0;
    end else begin
      if (strobe.allocDo)  tailQ <= bump(tailQ);
      if (strobe.commitDo) headQ <= bump(headQ);
      occQ <= occQ + CNT_W'(strobe.allocDo) - CNT_W'(strobe.commitDo);
    end
  end

  assign headPtr   = headQ;
  assign tailPtr   = tailQ;
  assign occupancy = occQ;

endmodule

// File: rtl/retire_store.sv
module retire_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  retire_pkg::slot_strobe_t  strobe,
  input  logic [TAG_W-1:0]          allocIdx,
  input  logic [TAG_W-1:0]          headIdx,
  input  logic [1:0]                allocKind,
  input  logic [REG_W-1:0]          allocDest,
  input  logic                      wbValid,
  input  logic [TAG_W-1:0]          wbTag,
  input  logic [DATA_W-1:0]         wbValue,
  input  logic [ADDR_W-1:0]         wbAux,
  input  logic                      wbMispredict,
  output logic                      headDone,
  output logic                      headMisBranch,
  output logic [1:0]                headKind,
  output logic [REG_W-1:0]          headDest,
  output logic [DATA_W-1:0]         headValue,
  output logic [ADDR_W-1:0]         headAux
);
  import retire_pkg::*;

  logic [DEPTH-1:0]  liveVec;
  logic [DEPTH-1:0]  doneVec;
  logic [DEPTH-1:0]  misVec;
  logic [1:0]        kindArr  [DEPTH];
  logic [REG_W-1:0]  destArr  [DEPTH];
  logic [DATA_W-1:0] valueArr [DEPTH];
  logic [ADDR_W-1:0] auxArr   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              liveQ, doneQ, misQ;
    logic [1:0]        kindQ;
    logic [REG_W-1:0]  destQ;
    logic [DATA_W-1:0] valueQ;
    logic [ADDR_W-1:0] auxQ;
    logic              allocHit, retireHit, wbHit;

    always_comb begin
      allocHit  = strobe.allocDo  && (allocIdx == TAG_W'(i));
      retireHit = strobe.commitDo && (headIdx  == TAG_W'(i));
      wbHit     = wbValid && (wbTag == TAG_W'(i)) && liveQ && !doneQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ <= 1'b0;
        doneQ <= 1'b0;
      end else if (strobe.flushDo) begin
        liveQ <= 1'b0;
        doneQ <= 1'b0;
      end else if (allocHit) begin
        liveQ <= 1'b1;
        doneQ <= 1'b0;
      end else if (retireHit) begin
        liveQ <= 1'b0;
        doneQ <= 1'b0;
      end else if (wbHit) begin
        doneQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (allocHit) begin
        kindQ <= allocKind;
        destQ <= allocDest;
      end
      if (wbHit) begin
        valueQ <= wbValue;
        auxQ   <= wbAux;
        misQ   <= wbMispredict;
      end
    end

    assign liveVec[i]  = liveQ;
    assign doneVec[i]  = doneQ;
    assign misVec[i]   = misQ;
    assign kindArr[i]  = kindQ;
    assign destArr[i]  = destQ;
    assign valueArr[i] = valueQ;
    assign auxArr[i]   = auxQ;
  end

  always_comb begin
    headDone      = liveVec[headIdx] && doneVec[headIdx];
    headKind      = kindArr[headIdx];
    headDest      = destArr[headIdx];
    headValue     = valueArr[headIdx];
    headAux       = auxArr[headIdx];
    headMisBranch = (kindArr[headIdx] == KIND_BRANCH) && misVec[headIdx];
  end

endmodule

// File: rtl/retire_buffer.sv
module retire_buffer #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocReq,
  input  logic [1:0]        allocKind,
  input  logic [REG_W-1:0]  allocDest,
  output logic              allocReady,
  output logic [TAG_W-1:0]  allocTag,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic [ADDR_W-1:0] wbAux,
  input  logic              wbMispredict,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              flushOut,
  output logic [ADDR_W-1:0] redirectPc
);
  import retire_pkg::*;

  slot_strobe_t      strobe;
  logic [TAG_W-1:0]  headPtr, tailPtr;
  logic [CNT_W-1:0]  occupancy;
  logic              headDone, headMisBranch;
  logic [1:0]        headKind;
  logic [REG_W-1:0]  headDest;
  logic [DATA_W-1:0] headValue;
  logic [ADDR_W-1:0] headAux;

  retire_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .allocReq      (allocReq),
    .headDone      (headDone),
    .headMisBranch (headMisBranch),
    .strobe        (strobe),
    .headPtr       (headPtr),
    .tailPtr       (tailPtr),
    .occupancy     (occupancy),
    .allocReady    (allocReady)
  );

  retire_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) store_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .allocIdx      (tailPtr),
    .headIdx       (headPtr),
    .allocKind     (allocKind),
    .allocDest     (allocDest),
    .wbValid       (wbValid),
    .wbTag         (wbTag),
    .wbValue       (wbValue),
    .wbAux         (wbAux),
    .wbMispredict  (wbMispredict),
    .headDone      (headDone),
    .headMisBranch (headMisBranch),
    .headKind      (headKind),
    .headDest      (headDest),
    .headValue     (headValue),
    .headAux       (headAux)
  );

  always_comb begin
    allocTag   = tailPtr;
    regWrEn    = strobe.commitDo &&
                 (headKind == KIND_REG || headKind == KIND_REGALT);
    memWrEn    = strobe.commitDo && (headKind == KIND_STORE);
    flushOut   = strobe.flushDo;
    regWrIdx   = headDest;
    regWrData  = headValue;
    memWrAddr  = headAux;
    memWrData  = headValue;
    redirectPc = strobe.flushDo ? headAux : '0;
  end

endmodule

// File: rtl/retire_buffer_chk.sv
module retire_buffer_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocReq,
  input logic             allocReady,
  input logic [TAG_W-1:0] allocTag,
  input logic             regWrEn,
  input logic             memWrEn,
  input logic             flushOut,
  input logic [CNT_W-1:0] occupancy
);

  function automatic logic [TAG_W-1:0] nextTag(input logic [TAG_W-1:0] t);
    return (t == TAG_W'(DEPTH - 1)) ? '0 : t + 1'b1;
  endfunction

  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && allocReady && !flushOut) |=> (allocTag == nextTag($past(allocTag)))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH)); // R3

  AST_FULL_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (!allocReady && !regWrEn && !memWrEn && !flushOut) |=> $stable(allocTag)); // R3

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> (occupancy == '0 && allocTag == '0 && allocReady)); // R8

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, memWrEn, flushOut})); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !flushOut |=> ((occupancy <= $past(occupancy) + 1'b1) &&
                   (occupancy + 1'b1 >= $past(occupancy)))); // R11

endmodule

bind retire_buffer retire_buffer_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .allocReq   (allocReq),
  .allocReady (allocReady),
  .allocTag   (allocTag),
  .regWrEn    (regWrEn),
  .memWrEn    (memWrEn),
  .flushOut   (flushOut),
  .occupancy  (occupancy)
);

// File: tb/retire_buffer_tb_top.sv
module retire_buffer_tb_top;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 5;
  localparam int TAG_W  = 3;
  localparam int NVEC   = 6;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  dest;
    logic [31:0] value;
    logic [31:0] aux;
  } vec_t;

  // kind 0/3 register, 1 store, 2 branch (never mispredicted here)
  localparam vec_t VECS [NVEC] = '{
    '{kind: 2'd0, dest: 5'd3,  value: 32'h0000_0011, aux: 32'h0},
    '{kind: 2'd1, dest: 5'd0,  value: 32'h0000_0022, aux: 32'h0000_0080},
    '{kind: 2'd2, dest: 5'd0,  value: 32'h0,         aux: 32'h0000_0099},
    '{kind: 2'd3, dest: 5'd31, value: 32'h0000_0044, aux: 32'h0},
    '{kind: 2'd1, dest: 5'd0,  value: 32'h0000_0055, aux: 32'h0000_1000},
    '{kind: 2'd0, dest: 5'd9,  value: 32'hDEAD_BEEF, aux: 32'h0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              allocReq;
  logic [1:0]        allocKind;
  logic [REG_W-1:0]  allocDest;
  logic              allocReady;
  logic [TAG_W-1:0]  allocTag;
  logic              wbValid;
  logic [TAG_W-1:0]  wbTag;
  logic [DATA_W-1:0] wbValue;
  logic [ADDR_W-1:0] wbAux;
  logic              wbMispredict;
  logic              regWrEn;
  logic [REG_W-1:0]  regWrIdx;
  logic [DATA_W-1:0] regWrData;
  logic              memWrEn;
  logic [ADDR_W-1:0] memWrAddr;
  logic [DATA_W-1:0] memWrData;
  logic              flushOut;
  logic [ADDR_W-1:0] redirectPc;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  retire_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocKind(allocKind), .allocDest(allocDest),
    .allocReady(allocReady), .allocTag(allocTag),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue), .wbAux(wbAux),
    .wbMispredict(wbMispredict),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .flushOut(flushOut), .redirectPc(redirectPc)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    allocReq = 1'b0; allocKind = 2'd0; allocDest = '0;
    wbValid = 1'b0; wbTag = '0; wbValue = '0; wbAux = '0; wbMispredict = 1'b0;
  endtask

  task automatic doAlloc(input logic [1:0] k, input logic [4:0] d);
    idle();
    allocReq = 1'b1; allocKind = k; allocDest = d;
  endtask

  task automatic doWb(input logic [2:0] t, input logic [31:0] v,
                      input logic [31:0] a, input logic m);
    idle();
    wbValid = 1'b1; wbTag = t; wbValue = v; wbAux = a; wbMispredict = m;
  endtask

  task automatic noRetire(input string req);
    check(!regWrEn && !memWrEn && !flushOut, req,
          {61'b0, regWrEn, memWrEn, flushOut}, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] expTag;
    rstN = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(allocReady, "R1 ready", 64'(allocReady), 64'h1);
    check(allocTag == 3'd0, "R1 tag", 64'(allocTag), 64'h0);
    noRetire("R1 outputs");

    // table: allocate every row, tags must run 0..5 (R2)
    for (int i = 0; i < NVEC; i++) begin
      check(allocTag == 3'(i), "R2 table tag", 64'(allocTag), 64'(i));
      doAlloc(VECS[i].kind, VECS[i].dest);
      @(negedge clk);
    end
    // complete youngest first; nothing may retire yet (R4)
    for (int i = NVEC - 1; i >= 1; i--) begin
      doWb(3'(i), VECS[i].value, VECS[i].aux, 1'b0);
      @(negedge clk);
      noRetire("R4 waits for head");
    end
    doWb(3'd0, VECS[0].value, VECS[0].aux, 1'b0);
    @(negedge clk);
    idle();
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].kind == 2'd1) begin
        check(memWrEn && !regWrEn && memWrAddr == VECS[i].aux && memWrData == VECS[i].value,
              "R6 store retire", {memWrAddr, memWrData}, {VECS[i].aux, VECS[i].value});
      end else if (VECS[i].kind == 2'd2) begin
        noRetire("R7 silent branch");
      end else begin
        check(regWrEn && regWrIdx == VECS[i].dest && regWrData == VECS[i].value,
              "R5 reg retire in order R4", {27'b0, regWrIdx, regWrData},
              {27'b0, VECS[i].dest, VECS[i].value});
      end
      @(negedge clk);
    end
    noRetire("R4 drained");

    // fill to full across the wrap point (R2, R3)
    expTag = 3'd6;
    for (int i = 0; i < DEPTH; i++) begin
      check(allocTag == expTag, "R2 wrap tag", 64'(allocTag), 64'(expTag));
      doAlloc(2'd0, 5'(i));
      @(negedge clk);
      expTag = expTag + 3'd1;
    end
    idle();
    check(!allocReady, "R3 full ready", 64'(allocReady), 64'h0);
    doAlloc(2'd0, 5'd20);
    @(negedge clk);
    check(!allocReady && allocTag == 3'd6, "R3 full ignores request",
          {allocReady, allocTag}, {1'b0, 3'd6});
    for (int i = 0; i < DEPTH; i++) begin
      doWb(3'(6 + i), 32'(100 + i), 32'h0, 1'b0);
      @(negedge clk);
      check(regWrEn && regWrData == 32'(100 + i), "R5 full drain", 64'(regWrData), 64'(100 + i));
    end
    idle();
    @(negedge clk);
    noRetire("R3 no extra slot");

    // misprediction flush (R8, R9)
    doAlloc(2'd2, 5'd0);  @(negedge clk);   // tag 6
    doAlloc(2'd0, 5'd7);  @(negedge clk);   // tag 7
    doAlloc(2'd0, 5'd8);  @(negedge clk);   // tag 0
    doAlloc(2'd1, 5'd0);  @(negedge clk);   // tag 1
    doWb(3'd7, 32'h77, 32'h0, 1'b0);  @(negedge clk);
    doWb(3'd1, 32'h11, 32'h200, 1'b0); @(negedge clk);
    noRetire("R4 branch pending");
    doWb(3'd6, 32'h0, 32'h400, 1'b1);
    @(negedge clk);
    check(flushOut && redirectPc == 32'h400 && !regWrEn && !memWrEn, "R8 flush redirect",
          {31'b0, flushOut, redirectPc}, {31'b0, 1'b1, 32'h400});
    doAlloc(2'd0, 5'd5);
    wbValid = 1'b1; wbTag = 3'd0; wbValue = 32'h88;
    @(negedge clk);
    idle();
    check(!flushOut, "R8 single pulse", 64'(flushOut), 64'h0);
    check(allocTag == 3'd0 && allocReady, "R9 alloc dropped", 64'(allocTag), 64'h0);
    noRetire("R8 younger discarded");

    // stale write-back (R10)
    doWb(3'd2, 32'hBAD, 32'h0, 1'b0); @(negedge clk);
    doAlloc(2'd0, 5'd10); @(negedge clk);
    doAlloc(2'd0, 5'd11); @(negedge clk);
    check(allocTag == 3'd2, "R2 tag after flush", 64'(allocTag), 64'h2);
    doAlloc(2'd0, 5'd12); @(negedge clk);
    doWb(3'd0, 32'hA0, 32'h0, 1'b0); @(negedge clk);
    check(regWrEn && regWrIdx == 5'd10 && regWrData == 32'hA0, "R10 first", 64'(regWrData), 64'hA0);
    doWb(3'd1, 32'hA1, 32'h0, 1'b0); @(negedge clk);
    check(regWrEn && regWrIdx == 5'd11 && regWrData == 32'hA1, "R10 second", 64'(regWrData), 64'hA1);
    idle(); @(negedge clk);
    noRetire("R10 stale write ignored");
    doWb(3'd2, 32'hC2, 32'h0, 1'b0); @(negedge clk);
    idle();
    check(regWrEn && regWrIdx == 5'd12 && regWrData == 32'hC2, "R10 fresh value",
          64'(regWrData), 64'hC2);
    @(negedge clk);
    noRetire("R11 single retire");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule